// File: doc/BRIEF.md
# Return Address Adjust Stack Unit

This unit handles subroutine and interrupt control transfers for a small 16-bit processor with a 20-bit byte address space. Instruction prefetch keeps the live program counter six bytes ahead of the instruction that is executing. Each call or return command therefore corrects the return address by a fixed amount before pushing it to, or after popping it from, an internal return-address LIFO. The corrections are chosen so that the shared return paths work for calls of one word and of two words.

Each cycle the unit takes one command code together with the current program counter and an operand. The operand is a displacement, an absolute target or a vector address, depending on the command. One cycle later it reports the redirect target for one cycle. All address arithmetic wraps modulo 2^20. If the LIFO is full when a push is asked for, or empty when a pop is asked for, the unit sets a sticky error flag and leaves the stack as it was. It still reports a defined target.

Top module: `retaddr_unit`

## Requirements
- R1: After reset, `redir_valid` is 0 and `stack_err` is 0, and the LIFO is empty.
- R2: Command 1 (short call): the unit pushes pc−2 and targets pc plus `operand_in[7:0]` sign-extended.
- R3: Command 2 (long call): the unit pushes pc unchanged and targets pc plus `operand_in[15:0]` sign-extended.
- R4: Command 3 (absolute call): the unit pushes pc unchanged and targets `operand_in[19:0]`.
- R5: Command 4 (subroutine return): the unit pops the top entry and targets that value minus 2.
- R6: Command 6 (asynchronous interrupt entry): the unit pushes pc unchanged and targets the vector in `operand_in`.
- R7: Command 5 (software interrupt): the unit pushes pc+2 and targets the vector in `operand_in`.
- R8: Command 7 (interrupt return): the unit pops the top entry and targets that value minus 6.
- R9: `redir_valid` is 1 in exactly the cycle after a nonzero command. Command 0 (idle) produces no redirect and leaves the stack untouched.
- R10: All address sums and differences wrap modulo 2^20.
- R11: The LIFO holds 16 entries. A push while it is full sets `stack_err` and leaves the stack unchanged, and the call target is still reported. `stack_err` stays set until reset.
- R12: A pop while the LIFO is empty sets `stack_err` and uses 0 as the popped value, so a subroutine return targets 0xFFFFE and an interrupt return targets 0xFFFFA.
- R13: A matched pair, nested or not, resumes at the instruction after the call or after the interrupted point. That is the call address +2 for a short call, the call address +4 for a long or absolute call, the software-interrupt address +2, and the boundary address for an asynchronous interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code (0 idle, 1..7 as in the requirements) |
| pc_in | input | 20 | Program counter presented with the command |
| operand_in | input | 20 | Displacement, absolute target or vector |
| redir_valid | output | 1 | Redirect target valid, one cycle per command |
| redir_addr | output | 20 | Redirect target address |
| stack_err | output | 1 | Sticky overflow/underflow flag |

## Verification
Every result is due one clock edge after its command. The stack update, the redirect target and the error flag are all registered at that same edge. The bench drives each command on a falling edge and compares all three outputs against its queue-based model on the next falling edge. Idle cycles are checked the same way to confirm that no redirect appears. The resume checks compare the reported return target with the instruction address that the bench derives from instruction length, not with the model's stack arithmetic.

// File: rtl/retaddr_pkg.sv
package retaddr_pkg;
    parameter int unsigned ADDR_W    = 20;
    parameter int unsigned LIFO_DEPTH = 16;

    localparam int unsigned OFS_SHORT_CALL = 2;
    localparam int unsigned OFS_SOFT_INT   = 2;
    localparam int unsigned OFS_SUB_RET    = 2;
    localparam int unsigned OFS_INT_RET    = 6;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_CALL_S = 3'd1,
        OP_CALL_L = 3'd2,
        OP_CALL_A = 3'd3,
        OP_SUBRET = 3'd4,
        OP_SWINT  = 3'd5,
        OP_HWINT  = 3'd6,
        OP_INTRET = 3'd7
    } op_e;
endpackage

// File: rtl/retaddr_adjust.sv
module retaddr_adjust
    import retaddr_pkg::*;
(
    input  op_e   op,
    input  addr_t pc,
    input  addr_t operand,
    input  addr_t pop_val,
    output logic  push_req,
    output logic  pop_req,
    output addr_t push_val,
    output addr_t target
);
    localparam int unsigned EXT8  = ADDR_W - 8;
    localparam int unsigned EXT16 = ADDR_W - 16;

    addr_t disp8_sx;
    addr_t disp16_sx;

    always_comb begin
        disp8_sx  = {{EXT8{operand[7]}}, operand[7:0]};
        disp16_sx = {{EXT16{operand[15]}}, operand[15:0]};
        push_req  = 1'b0;
        pop_req   = 1'b0;
        push_val  = pc;
        target    = '0;
        unique case (op)
            OP_CALL_S: begin
                push_req = 1'b1;
                push_val = pc - addr_t'(OFS_SHORT_CALL);
                target   = pc + disp8_sx;
            end
            OP_CALL_L: begin
                push_req = 1'b1;
                target   = pc + disp16_sx;
            end
            OP_CALL_A: begin
                push_req = 1'b1;
                target   = operand;
            end
            OP_SWINT: begin
                push_req = 1'b1;
                push_val = pc + addr_t'(OFS_SOFT_INT);
                target   = operand;
            end
            OP_HWINT: begin
                push_req = 1'b1;
                target   = operand;
            end
            OP_SUBRET: begin
                pop_req = 1'b1;
                target  = pop_val - addr_t'(OFS_SUB_RET);
            end
            OP_INTRET: begin
                pop_req = 1'b1;
                target  = pop_val - addr_t'(OFS_INT_RET);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/retaddr_lifo.sv
module retaddr_lifo
    import retaddr_pkg::*;
#(
    parameter int unsigned DEPTH = LIFO_DEPTH
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  logic  pop,
    input  addr_t wdata,
    output addr_t top,
    output logic  empty,
    output logic  overflow,
    output logic  underflow
);
    localparam int unsigned IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned SPW = $clog2(DEPTH + 1);

    logic [SPW-1:0] sp_q, sp_d;
    logic [SPW-1:0] top_idx;
    logic           full;
    logic           wr_en;
    addr_t          mem_q [DEPTH];

    always_comb begin
        full      = (sp_q == SPW'(DEPTH));
        empty     = (sp_q == '0);
        overflow  = push && full;
        underflow = pop && empty;
        wr_en     = push && !full;
        sp_d      = sp_q;
        if (wr_en)
            sp_d = sp_q + 1'b1;
        else if (pop && !empty)
            sp_d = sp_q - 1'b1;
        top_idx = sp_q - 1'b1;
        top     = empty ? '0 : mem_q[top_idx[IW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && sp_q == SPW'(g))
                mem_q[g] <= wdata;
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(sp_q));
    p_push_grows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (sp_q == $past(sp_q) + 1'b1));
    p_underflow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (sp_q == '0));
endmodule

// File: rtl/retaddr_unit.sv
module retaddr_unit
    import retaddr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cmd_op,
    input  logic [19:0] pc_in,
    input  logic [19:0] operand_in,
    output logic        redir_valid,
    output logic [19:0] redir_addr,
    output logic        stack_err
);
    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  err;
    } state_t;

    state_t s_q, s_d;
    op_e    op;
    logic   push_req, pop_req;
    addr_t  push_val, target, lifo_top;
    logic   lifo_empty, lifo_ovf, lifo_unf;

    assign op = op_e'(cmd_op);

    retaddr_adjust u_adjust (
        .op       (op),
        .pc       (pc_in),
        .operand  (operand_in),
        .pop_val  (lifo_top),
        .push_req (push_req),
        .pop_req  (pop_req),
        .push_val (push_val),
        .target   (target)
    );

    retaddr_lifo #(.DEPTH(LIFO_DEPTH)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .pop       (pop_req),
        .wdata     (push_val),
        .top       (lifo_top),
        .empty     (lifo_empty),
        .overflow  (lifo_ovf),
        .underflow (lifo_unf)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = (op != OP_IDLE);
        s_d.addr  = target;
        s_d.err   = s_q.err | lifo_ovf | lifo_unf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign redir_valid = s_q.valid;
    assign redir_addr  = s_q.addr;
    assign stack_err   = s_q.err;

    p_redir_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 3'd0) |=> redir_valid);
    p_no_redir_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd0) |=> !redir_valid);
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
    p_subret_adjust_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd4 && !lifo_empty) |=> (redir_addr == addr_t'($past(lifo_top) - 20'd2)));
    p_intret_adjust_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd7 && !lifo_empty) |=> (redir_addr == addr_t'($past(lifo_top) - 20'd6)));
endmodule

// File: tb/retaddr_unit_tb.sv
module retaddr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [19:0] pc_in = '0;
    logic [19:0] operand_in = '0;
    logic        redir_valid;
    logic [19:0] redir_addr;
    logic        stack_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [19:0] mdl_stack[$];
    logic        mdl_err = 1'b0;
    logic [19:0] last_addr;

    always #5 clk = ~clk;

    retaddr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .pc_in(pc_in),
        .operand_in(operand_in), .redir_valid(redir_valid),
        .redir_addr(redir_addr), .stack_err(stack_err)
    );

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic idle(input string req);
        cmd_op = 3'd0;
        @(negedge clk);
        check({req, " valid"}, {19'd0, redir_valid}, 20'd0);
        check({req, " err"}, {19'd0, stack_err}, {19'd0, mdl_err});
    endtask

    task automatic cmd(input logic [2:0] op, input logic [19:0] pc,
                       input logic [19:0] opd, input string req);
        logic [19:0] exp;
        logic [19:0] v;
        exp = '0;
        cmd_op = op; pc_in = pc; operand_in = opd;
        case (op)
            3'd1, 3'd2, 3'd3, 3'd5, 3'd6: begin
                case (op)
                    3'd1: begin v = pc - 20'd2; exp = pc + {{12{opd[7]}}, opd[7:0]}; end
                    3'd2: begin v = pc; exp = pc + {{4{opd[15]}}, opd[15:0]}; end
                    3'd5: begin v = pc + 20'd2; exp = opd; end
                    default: begin v = pc; exp = opd; end
                endcase
                if (mdl_stack.size() >= 16) mdl_err = 1'b1;
                else mdl_stack.push_back(v);
            end
            3'd4, 3'd7: begin
                if (mdl_stack.size() == 0) begin v = '0; mdl_err = 1'b1; end
                else v = mdl_stack.pop_back();
                exp = (op == 3'd4) ? v - 20'd2 : v - 20'd6;
            end
            default: ;
        endcase
        @(negedge clk);
        check({req, " valid"}, {19'd0, redir_valid}, 20'd1);
        check({req, " target"}, redir_addr, exp);
        check({req, " err"}, {19'd0, stack_err}, {19'd0, mdl_err});
        last_addr = redir_addr;
        cmd_op = 3'd0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", {19'd0, redir_valid}, 20'd0);
        check("R1 err", {19'd0, stack_err}, 20'd0);
        rst_n = 1'b1;
        idle("R9 idle");
        idle("R9 idle");

        // nested subroutine pair: absolute call at 0x12340, short call at 0x50010
        cmd(3'd3, 20'h12346, 20'h50000, "R4 abs call");
        cmd(3'd1, 20'h50016, 20'h00080, "R2 short call neg disp");
        idle("R9 idle between");
        cmd(3'd4, 20'h4FFA0, 20'h0, "R5 return inner");
        check("R13 short call resume", last_addr, 20'h50010 + 20'd2);
        cmd(3'd4, 20'h50006, 20'h0, "R5 return outer");
        check("R13 abs call resume", last_addr, 20'h12340 + 20'd4);

        // long call, async interrupt, software interrupt nested
        cmd(3'd2, 20'h20006, 20'h01000, "R3 long call");
        cmd(3'd6, 20'h21006, 20'h00100, "R6 async interrupt");
        cmd(3'd5, 20'h00126, 20'h00200, "R7 software interrupt");
        cmd(3'd7, 20'h00206, 20'h0, "R8 return swint");
        check("R13 swint resume", last_addr, 20'h00120 + 20'd2);
        cmd(3'd7, 20'h00130, 20'h0, "R8 return async");
        check("R13 async resume", last_addr, 20'h21000);
        cmd(3'd4, 20'h21010, 20'h0, "R5 return long");
        check("R13 long call resume", last_addr, 20'h20000 + 20'd4);
        cmd(3'd1, 20'h30006, 20'h0007F, "R2 short call pos disp");
        cmd(3'd4, 20'h30090, 20'h0, "R5 return");
        check("R13 short resume 2", last_addr, 20'h30002);

        // R10 wrap
        cmd(3'd1, 20'h00001, 20'h000F0, "R10 short call wrap");
        cmd(3'd2, 20'hFFFFE, 20'h00010, "R10 long call wrap");
        cmd(3'd4, 20'h0, 20'h0, "R10 return wrap");
        cmd(3'd4, 20'h0, 20'h0, "R10 return wrap low");

        // R11 overflow
        for (int i = 0; i < 16; i++)
            cmd(3'd3, 20'h40006 + 20'(i * 16), 20'h60000 + 20'(i), "R11 fill");
        idle("R11 full idle");
        cmd(3'd3, 20'h7FFF6, 20'h61234, "R11 overflow push");
        for (int i = 0; i < 16; i++)
            cmd(3'd4, 20'h0, 20'h0, "R11 drain");
        check("R11 oldest intact", last_addr, 20'h40006 - 20'd2);
        cmd(3'd7, 20'h0, 20'h0, "R12 underflow intret");
        check("R12 intret empty target", last_addr, 20'hFFFFA);
        cmd(3'd4, 20'h0, 20'h0, "R12 underflow subret");
        check("R12 subret empty target", last_addr, 20'hFFFFE);
        idle("R11 sticky");

        // R1: reset clears the flag and empties the stack
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mdl_err = 1'b0;
        mdl_stack.delete();
        check("R1 err after reset", {19'd0, stack_err}, 20'd0);
        cmd(3'd4, 20'h0, 20'h0, "R1 empty after reset");
        finish_run();
    end
endmodule